// File: doc/BRIEF.md
# Grouped Wake-Up Interrupt Aggregator

This block collects every interrupt source that is allowed to wake the system and presents the result as a 64-bit top-level view. Each top-level bit has a pending read and an enable bit. Bit 0 carries the non-maskable line. The next `FIRST_MUX-1` bits carry direct peripheral lines, and some of these come from banked peripherals that have no CPU interrupt of their own. The upper bits each summarise a group of eight multiplexed lines. Every multiplexed line first passes through its own gate bit, and the gated lines of a group are ORed into a single top-level bit.

Software configures the block through a plain word-addressed read/write port. It sets the top-level enables, the per-line mux gates and a two-bit trigger mode for the non-maskable input. The trigger mode is handed to an external latch. The block drives the live pending vector on a port. It also drives one wake request, registered once, that is high whenever any enabled pending bit was high on the previous clock.

Top module: `wake_aggregator`

## Requirements
- R1: After a synchronous active-low reset, the enable word at 0x40 reads 0x00000001, the enable word at 0x44 reads 0, the mux-gate words read 0, the trigger mode reads 0 and `wake_req` is 0.
- R2: Enable bits 31..0 are written and read at offset 0x40, and bits 63..32 at offset 0x44. A write takes effect on the next clock.
- R3: For every top-level bit d below `FIRST_MUX`, pending bit d equals the source of bit d ANDed with enable bit d. The source of bit 0 is `nmi_in`, and the source of bit d ≥ 1 is `direct_src[d-1]`. Pending bits 31..0 read at 0x10, bits 63..32 read at 0x14, and the same value drives `pend_out` in the same cycle.
- R4: Top-level bit `FIRST_MUX+g` is pending when its enable bit is set and at least one of mux lines 8g..8g+7 is high while its gate bit is set. Gate bit m is bit m%32 of the word at 0xC0 + 4·(m/32).
- R5: Gate bits outside `MUX_VALID` cannot be set and read as 0. With the default mask, word 0xC4 keeps only bits 31..19 and word 0xCC keeps only bits 3..0.
- R6: Writes to the pending words at 0x10 and 0x14 change no register and no pending bit.
- R7: Top-level bits at or above `FIRST_MUX+MUX_GROUPS` are never pending, even when they are enabled and every source is high.
- R8: `wake_req` equals the OR of all 64 pending bits as sampled at the previous rising clock edge.
- R9: The trigger mode is written through bits 1..0 of offset 0x0C. It reads back in those bits, with all higher bits 0, and it drives `trig_mode`.
- R10: Reads at any offset other than the mapped words (including unaligned offsets) return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_in | input | 1 | Level of the latched non-maskable source, top-level bit 0 |
| direct_src | input | FIRST_MUX-1 | Direct source lines for top-level bits 1..FIRST_MUX-1 |
| mux_src | input | MUX_BITS | Multiplexed source lines |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pend_out | output | TOP_BITS | Live pending vector (source AND enable) |
| wake_req | output | 1 | Registered OR of all pending bits |
| trig_mode | output | 2 | Trigger mode for the external non-maskable latch |

## Verification
The direct path is driven with an alternating source pattern under full enable and then under a partial enable. This separates a design that ignores the enable from one that ignores the source. The mux fold is tried with a line whose gate is clear, a line whose gate is set, lines in the first and last groups, and lines whose gate bit lies outside the valid mask. Together these cases expose wrong group indexing, a missing gate, and a valid mask that is not applied. An all-ones stimulus with every enable set shows that unused upper bits stay quiet. A source that falls to zero, and an enable cleared while its source stays high, show the one-cycle delay of the wake output and its dependence on the enable.

// File: rtl/wake_pkg.sv
// Shared constants for the wake-up aggregator: register offsets and group geometry.
package wake_pkg;
    localparam int unsigned REG_AW   = 8;
    localparam int unsigned REG_DW   = 32;
    localparam int unsigned GROUP_SZ = 8;

    localparam logic [REG_AW-1:0] OFS_CTRL   = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_PEND0  = 8'h10;
    localparam logic [REG_AW-1:0] OFS_EN0    = 8'h40;
    localparam logic [REG_AW-1:0] OFS_MUXEN0 = 8'hC0;
endpackage

// File: rtl/wake_regs.sv
// Register file and read decode for the aggregator.
// Holds top-level enables, per-line mux gates and the trigger mode.
// Assumes word-aligned accesses. Any other offset reads 0 and ignores writes.
module wake_regs
    import wake_pkg::*;
#(
    parameter int unsigned    TOP_BITS  = 64,
    parameter int unsigned    MUX_BITS  = 128,
    parameter logic [127:0]   MUX_VALID = {128{1'b1}}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_AW-1:0]   addr,
    input  logic [REG_DW-1:0]   wr_data,
    input  logic [TOP_BITS-1:0] pend,
    output logic [REG_DW-1:0]   rd_data,
    output logic [TOP_BITS-1:0] en_q,
    output logic [MUX_BITS-1:0] mux_en_q,
    output logic [1:0]          ctrl_q
);
    localparam int unsigned EN_WORDS  = TOP_BITS / REG_DW;
    localparam int unsigned MUX_WORDS = MUX_BITS / REG_DW;
    localparam logic [MUX_BITS-1:0] VALID_M = MUX_VALID[MUX_BITS-1:0];

    // Register update: reset defaults, then word writes by offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= TOP_BITS'(1);
            mux_en_q <= '0;
            ctrl_q   <= '0;
        end else if (wr_en) begin
            if (addr == OFS_CTRL)
                ctrl_q <= wr_data[1:0];
            for (int w = 0; w < EN_WORDS; w++)
                if (addr == OFS_EN0 + REG_AW'(4 * w))
                    en_q[w*REG_DW +: REG_DW] <= wr_data;
            for (int w = 0; w < MUX_WORDS; w++)
                if (addr == OFS_MUXEN0 + REG_AW'(4 * w))
                    mux_en_q[w*REG_DW +: REG_DW] <= wr_data & VALID_M[w*REG_DW +: REG_DW];
        end
    end

    // Read decode: select the word addressed, zero otherwise.
    always_comb begin
        rd_data = '0;
        if (addr == OFS_CTRL)
            rd_data = {{(REG_DW-2){1'b0}}, ctrl_q};
        for (int w = 0; w < EN_WORDS; w++) begin
            if (addr == OFS_PEND0 + REG_AW'(4 * w))
                rd_data = pend[w*REG_DW +: REG_DW];
            if (addr == OFS_EN0 + REG_AW'(4 * w))
                rd_data = en_q[w*REG_DW +: REG_DW];
        end
        for (int w = 0; w < MUX_WORDS; w++)
            if (addr == OFS_MUXEN0 + REG_AW'(4 * w))
                rd_data = mux_en_q[w*REG_DW +: REG_DW];
    end
endmodule

// File: rtl/wake_fold.sv
// Builds the top-level source vector.
// Bit 0 is the non-maskable level and the next bits are direct lines.
// Each group of eight gated mux lines folds into one bit, starting at FIRST_MUX.
// Assumes FIRST_MUX + MUX_GROUPS <= TOP_BITS and 8*MUX_GROUPS <= MUX_BITS.
module wake_fold
    import wake_pkg::*;
#(
    parameter int unsigned TOP_BITS   = 64,
    parameter int unsigned MUX_BITS   = 128,
    parameter int unsigned FIRST_MUX  = 19,
    parameter int unsigned MUX_GROUPS = 13
) (
    input  logic                 nmi_in,
    input  logic [FIRST_MUX-2:0] direct_src,
    input  logic [MUX_BITS-1:0]  mux_src,
    input  logic [MUX_BITS-1:0]  mux_en_q,
    output logic [TOP_BITS-1:0]  src_top
);
    localparam int unsigned TOP_USED = FIRST_MUX + MUX_GROUPS;
    localparam int unsigned MUX_USED = GROUP_SZ * MUX_GROUPS;

    // Direct part of the source vector.
    assign src_top[0]             = nmi_in;
    assign src_top[FIRST_MUX-1:1] = direct_src;

    // One OR-reduction per group of gated mux lines.
    for (genvar g = 0; g < MUX_GROUPS; g++) begin : g_group
        assign src_top[FIRST_MUX+g] =
            |(mux_src[g*GROUP_SZ +: GROUP_SZ] & mux_en_q[g*GROUP_SZ +: GROUP_SZ]);
    end

    // Top-level bits with no group behind them stay low.
    for (genvar b = TOP_USED; b < TOP_BITS; b++) begin : g_idle
        assign src_top[b] = 1'b0;
    end

    // Mux lines beyond the last group feed nothing.
    if (MUX_USED < MUX_BITS) begin : g_spare
        logic unused_spare;
        assign unused_spare = ^{mux_src[MUX_BITS-1:MUX_USED], mux_en_q[MUX_BITS-1:MUX_USED]};
    end
endmodule

// File: rtl/wake_pend.sv
// Gates the source vector with the enables and registers the wake request.
module wake_pend #(
    parameter int unsigned TOP_BITS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TOP_BITS-1:0] src_top,
    input  logic [TOP_BITS-1:0] en_q,
    output logic [TOP_BITS-1:0] pend,
    output logic                wake_q
);
    // Pending view: live source ANDed with enable.
    assign pend = src_top & en_q;

    // Wake request: one register stage after the OR of pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= |pend;
    end
endmodule

// File: rtl/wake_aggregator.sv
// Top of the wake-up aggregator.
// Folds direct and grouped mux sources into a 64-bit pending/enable view.
// Drives a registered wake request.
// Assumes a synchronous active-low reset and word-aligned register accesses.
module wake_aggregator
    import wake_pkg::*;
#(
    parameter int unsigned  TOP_BITS   = 64,
    parameter int unsigned  MUX_BITS   = 128,
    parameter int unsigned  FIRST_MUX  = 19,
    parameter int unsigned  MUX_GROUPS = 13,
    parameter logic [127:0] MUX_VALID  = 128'h0000000F_FFFFFFFF_FFF80000_FFFFFFFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 nmi_in,
    input  logic [FIRST_MUX-2:0] direct_src,
    input  logic [MUX_BITS-1:0]  mux_src,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [TOP_BITS-1:0]  pend_out,
    output logic                 wake_req,
    output logic [1:0]           trig_mode
);
    logic [TOP_BITS-1:0] en_q;
    logic [MUX_BITS-1:0] mux_en_q;
    logic [TOP_BITS-1:0] src_top;

    wake_regs #(
        .TOP_BITS (TOP_BITS),
        .MUX_BITS (MUX_BITS),
        .MUX_VALID(MUX_VALID)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wr_data (reg_wdata),
        .pend    (pend_out),
        .rd_data (reg_rdata),
        .en_q    (en_q),
        .mux_en_q(mux_en_q),
        .ctrl_q  (trig_mode)
    );

    wake_fold #(
        .TOP_BITS  (TOP_BITS),
        .MUX_BITS  (MUX_BITS),
        .FIRST_MUX (FIRST_MUX),
        .MUX_GROUPS(MUX_GROUPS)
    ) i_fold (
        .nmi_in    (nmi_in),
        .direct_src(direct_src),
        .mux_src   (mux_src),
        .mux_en_q  (mux_en_q),
        .src_top   (src_top)
    );

    wake_pend #(
        .TOP_BITS(TOP_BITS)
    ) i_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_top(src_top),
        .en_q   (en_q),
        .pend   (pend_out),
        .wake_q (wake_req)
    );
endmodule

// File: rtl/wake_aggregator_chk.sv
// Property checker for wake_aggregator, attached by bind.
module wake_aggregator_chk #(
    parameter int unsigned  TOP_BITS   = 64,
    parameter int unsigned  MUX_BITS   = 128,
    parameter int unsigned  FIRST_MUX  = 19,
    parameter int unsigned  MUX_GROUPS = 13,
    parameter logic [127:0] MUX_VALID  = '1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [7:0]          reg_addr,
    input logic [TOP_BITS-1:0] pend_out,
    input logic                wake_req,
    input logic [TOP_BITS-1:0] en_q,
    input logic [MUX_BITS-1:0] mux_en_q
);
    localparam int unsigned TOP_USED = FIRST_MUX + MUX_GROUPS;
    localparam logic [TOP_BITS-1:0] USED_M = (TOP_USED >= TOP_BITS) ? '1
                                           : ((TOP_BITS'(1) << TOP_USED) - TOP_BITS'(1));
    localparam logic [MUX_BITS-1:0] VALID_M = MUX_VALID[MUX_BITS-1:0];

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (en_q == TOP_BITS'(1) && mux_en_q == '0 && !wake_req));

    // R5
    valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_en_q & ~VALID_M) == '0);

    // R6
    pend_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == 8'h10 || reg_addr == 8'h14)) |=> ($stable(en_q) && $stable(mux_en_q)));

    // R7
    idle_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_out & ~USED_M) == '0);

    // R8
    wake_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (wake_req == $past(|pend_out)));
endmodule

bind wake_aggregator wake_aggregator_chk #(
    .TOP_BITS  (TOP_BITS),
    .MUX_BITS  (MUX_BITS),
    .FIRST_MUX (FIRST_MUX),
    .MUX_GROUPS(MUX_GROUPS),
    .MUX_VALID (MUX_VALID)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_wr  (reg_wr),
    .reg_addr(reg_addr),
    .pend_out(pend_out),
    .wake_req(wake_req),
    .en_q    (en_q),
    .mux_en_q(mux_en_q)
);

// File: tb/test_wake_aggregator.sv
module test_wake_aggregator;
    localparam int FIRST = 19;
    localparam int GROUPS = 13;
    localparam logic [127:0] VALID = {32'h0000000F, 32'hFFFFFFFF, 32'hFFF80000, 32'hFFFFFFFF};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         nmi_in = 1'b0;
    logic [17:0]  direct_src = '0;
    logic [127:0] mux_src = '0;
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [63:0]  pend_out;
    logic         wake_req;
    logic [1:0]   trig_mode;

    int checks = 0;
    int errors = 0;

    // Reference state
    logic [63:0]  m_en = 64'h1;
    logic [127:0] m_gate = '0;
    logic [1:0]   m_mode = '0;
    logic         m_wake = 1'b0;

    always #4 clk = ~clk;

    wake_aggregator i_wake_aggregator (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .direct_src(direct_src),
        .mux_src(mux_src), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pend_out(pend_out),
        .wake_req(wake_req), .trig_mode(trig_mode)
    );

    function automatic logic [63:0] model_pend();
        logic [63:0] p = '0;
        for (int b = 0; b < 64; b++) begin
            logic s = 1'b0;
            if (b == 0) s = nmi_in;
            else if (b < FIRST) s = direct_src[b-1];
            else if (b < FIRST + GROUPS)
                for (int k = 0; k < 8; k++)
                    if (mux_src[(b-FIRST)*8+k] && m_gate[(b-FIRST)*8+k]) s = 1'b1;
            p[b] = s && m_en[b];
        end
        return p;
    endfunction

    // Reference update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en <= 64'h1; m_gate <= '0; m_mode <= '0; m_wake <= 1'b0;
        end else begin
            m_wake <= (model_pend() != 0);
            if (reg_wr) begin
                case (reg_addr)
                    8'h0C: m_mode <= reg_wdata[1:0];
                    8'h40: m_en[31:0] <= reg_wdata;
                    8'h44: m_en[63:32] <= reg_wdata;
                    8'hC0: m_gate[31:0] <= reg_wdata & VALID[31:0];
                    8'hC4: m_gate[63:32] <= reg_wdata & VALID[63:32];
                    8'hC8: m_gate[95:64] <= reg_wdata & VALID[95:64];
                    8'hCC: m_gate[127:96] <= reg_wdata & VALID[127:96];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(pend_out == model_pend(), "R3/R4 pend_out", pend_out, model_pend());
            chk(wake_req == m_wake, "R8 wake_req", 64'(wake_req), 64'(m_wake));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(posedge clk); #2;
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic drive(input logic n, input logic [17:0] d, input logic [127:0] m);
        @(posedge clk); #2;
        nmi_in = n; direct_src = d; mux_src = m;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        rd(8'h40, 32'h1, "R1 enable low");
        rd(8'h44, 32'h0, "R1 enable high");
        rd(8'hC0, 32'h0, "R1 gate word0");
        rd(8'hCC, 32'h0, "R1 gate word3");
        rd(8'h0C, 32'h0, "R1 mode");
        chk(wake_req == 1'b0, "R1 wake", 64'(wake_req), 64'h0);
        // R2 enable access
        wr(8'h40, 32'hFFFFFFFF);
        wr(8'h44, 32'h000000FF);
        rd(8'h40, 32'hFFFFFFFF, "R2 enable low");
        rd(8'h44, 32'h000000FF, "R2 enable high");
        // R3 direct lines
        drive(1'b1, 18'h2A5A5, '0);
        rd(8'h10, 32'h00054B4B, "R3 direct full enable");
        wr(8'h40, 32'h00000F0F);
        rd(8'h10, 32'h00000B0B, "R3 direct partial enable");
        wr(8'h40, 32'hFFFFFFFF);
        // R4 mux fold
        drive(1'b0, '0, 128'h1);
        wr(8'hC0, 32'h000000F0);
        rd(8'h10, 32'h0, "R4 ungated line");
        drive(1'b0, '0, 128'h10);
        rd(8'h10, 32'h00080000, "R4 first group");
        wr(8'hCC, 32'hFFFFFFFF);
        rd(8'hCC, 32'h0000000F, "R5 last gate word");
        drive(1'b0, '0, (128'h1 << 97) | 128'h10);
        rd(8'h10, 32'h80080000, "R4 last group");
        drive(1'b0, '0, 128'h1 << 101);
        rd(8'h10, 32'h0, "R5 invalid line in last group");
        // R5 valid mask
        wr(8'hC4, 32'hFFFFFFFF);
        rd(8'hC4, 32'hFFF80000, "R5 gate word1");
        drive(1'b0, '0, 128'h1 << 40);
        rd(8'h10, 32'h0, "R5 invalid line");
        drive(1'b0, '0, 128'h1 << 60);
        rd(8'h10, 32'h04000000, "R4 group seven");
        // R6 pending writes ignored
        wr(8'h10, 32'h0);
        wr(8'h14, 32'hFFFFFFFF);
        rd(8'h10, 32'h04000000, "R6 pending low kept");
        rd(8'h14, 32'h0, "R6 pending high kept");
        rd(8'h40, 32'hFFFFFFFF, "R6 enable kept");
        // R7 idle upper bits
        wr(8'h44, 32'hFFFFFFFF);
        drive(1'b1, '1, '1);
        rd(8'h14, 32'h0, "R7 upper bits idle");
        rd(8'h10, 32'h860FFFFF, "R7 all ones low word");
        // R8 wake timing
        @(posedge clk); #1;
        chk(wake_req == 1'b1, "R8 wake high", 64'(wake_req), 64'h1);
        drive(1'b0, '0, '0);
        #1;
        chk(wake_req == 1'b1, "R8 wake before edge", 64'(wake_req), 64'h1);
        @(posedge clk); #1;
        chk(wake_req == 1'b0, "R8 wake after edge", 64'(wake_req), 64'h0);
        drive(1'b1, '0, '0);
        wr(8'h40, 32'h0);
        @(posedge clk); #1;
        chk(wake_req == 1'b0, "R8 wake gated by enable", 64'(wake_req), 64'h0);
        // R9 trigger mode
        wr(8'h0C, 32'hFFFFFFFF);
        rd(8'h0C, 32'h3, "R9 mode all ones");
        chk(trig_mode == 2'd3, "R9 mode port", 64'(trig_mode), 64'h3);
        wr(8'h0C, 32'h1);
        rd(8'h0C, 32'h1, "R9 mode one");
        // R10 unmapped offsets
        wr(8'h40, 32'h12345678);
        wr(8'h48, 32'hFFFFFFFF);
        wr(8'h50, 32'hFFFFFFFF);
        wr(8'h42, 32'hFFFFFFFF);
        wr(8'hD0, 32'hFFFFFFFF);
        rd(8'h40, 32'h12345678, "R10 enable low kept");
        rd(8'h44, 32'hFFFFFFFF, "R10 enable high kept");
        rd(8'h00, 32'h0, "R10 read 0x00");
        rd(8'h08, 32'h0, "R10 read 0x08");
        rd(8'h50, 32'h0, "R10 read 0x50");
        rd(8'hD0, 32'h0, "R10 read 0xD0");
        rd(8'h42, 32'h0, "R10 read unaligned");
        repeat (2) @(posedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule